// File: doc/BRIEF.md
# Interval Timer with Snapshot

A memory-mapped interval timer built around a 32-bit down-counter. Software programs a reload period through two 16-bit registers and starts or stops the count with separate write-one command bits. It also chooses whether the count repeats or stops after a single pass. When a running count reaches zero, a sticky timeout flag sets. If interrupts are enabled, an interrupt line rises.

Software cannot read the live count directly. It first writes the snapshot-low register, which copies the count into a 32-bit capture register. It then reads the capture as two 16-bit halves. With both period halves at 0xFFFF and repeat mode on, inverting each snapshot gives a free-running up-counter for timekeeping.

The register port is a plain single-cycle interface with no back-pressure. A write takes effect on the clock edge where `bus_wen` is high. Read data follows `bus_addr` combinationally and has no side effects. No valid/ready handshake applies, because the port always accepts a transfer.

Top module: `itimer_top`

## Requirements
- R1: Word offsets: 0 status, 1 control, 2 period low, 3 period high, 4 snapshot low, 5 snapshot high. Status bit 0 is the timeout flag and bit 1 is the running state. Control bit 0 enables the interrupt, bit 1 selects repeat mode, bit 2 is start and bit 3 is stop; control reads back bits 1:0. Period and snapshot registers keep only bits 15:0. Bits 31:16 of every read, and any unmapped offset, read as zero.
- R2: A write to either period half loads the counter with the full updated 32-bit period at that edge and halts it.
- R3: A control write with bit 3 set halts the counter, even when bit 2 is also set. A control write with bit 2 set alone makes it run from its current value, without a reload.
- R4: While running, the counter decreases by one on each clock. While halted, it holds its value.
- R5: A running counter that sits at zero causes a terminal event on the next edge, which sets the timeout flag. A period P therefore gives P+1 cycles per pass.
- R6: At a terminal event, repeat mode reloads the counter from the period and keeps running. Otherwise the counter stays at zero and halts.
- R7: Any write to status clears the timeout flag. A terminal event on the same edge keeps the flag set.
- R8: `irq` is high exactly when the timeout flag and the interrupt enable are both set.
- R9: Any write to offset 4, whatever its data, copies the counter value present before that edge into the snapshot register.
- R10: With a period of all ones in repeat mode, the inverted snapshot increases by one per elapsed clock, starting from zero.
- R11: After reset every register is zero, the counter is halted and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wen | input | 1 | Register write strobe |
| bus_addr | input | 3 | Word offset for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Interrupt request |

## Verification
The checker tests the following on every cycle:
- the one-step decrement and the hold while halted;
- the load-and-halt on a period write;
- stop winning over start;
- the flag set and the reload or halt at a terminal event;
- the status-write clear;
- snapshot capture;
- interrupt masking;
- the zero upper read bits.

Some behaviour is only visible as whole sequences, so the bench scenarios cover it. These include exact pass lengths measured through snapshots, a start that resumes without reloading, and a clear losing to a terminal event on the same edge. They also include the inverted free-running count, whose value is checked against elapsed clocks.

// File: rtl/itimer_pkg.sv
package itimer_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_STAT    = 3'd0,
    REG_CTRL    = 3'd1,
    REG_PER_LO  = 3'd2,
    REG_PER_HI  = 3'd3,
    REG_SNAP_LO = 3'd4,
    REG_SNAP_HI = 3'd5
  } reg_addr_e;

  // control bit positions
  localparam int CTL_IE    = 0;
  localparam int CTL_CONT  = 1;
  localparam int CTL_START = 2;
  localparam int CTL_STOP  = 3;

  // status bit positions
  localparam int ST_TO  = 0;
  localparam int ST_RUN = 1;
endpackage

// File: rtl/itimer_counter.sv
module itimer_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  input  logic             cont,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] cnt,
  output logic             done
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic at_zero;
  assign at_zero = (cnt == '0);
  // terminal event: running at zero, not overridden by a period load
  assign done    = run && at_zero && !load;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (run) begin
      if (!at_zero)  cnt <= cnt - ONE;
      else if (cont) cnt <= period;
    end
  end
endmodule

// File: rtl/itimer_regfile.sv
module itimer_regfile
  import itimer_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int HALF_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wen,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              done,
  output logic [CNT_W-1:0]  period,
  output logic [CNT_W-1:0]  load_val,
  output logic              per_wr,
  output logic              run,
  output logic              to_flag,
  output logic              ie,
  output logic              cont,
  output logic [CNT_W-1:0]  snap
);
  localparam int NHALF = CNT_W / HALF_W;

  logic [NHALF-1:0][HALF_W-1:0] per_q, per_next, snap_h;
  logic [NHALF-1:0]             per_hit;
  logic stat_wr, ctrl_wr, snap_wr, start_cmd, stop_cmd;

  assign stat_wr   = bus_wen && (bus_addr == REG_STAT);
  assign ctrl_wr   = bus_wen && (bus_addr == REG_CTRL);
  assign snap_wr   = bus_wen && (bus_addr == REG_SNAP_LO);
  assign start_cmd = ctrl_wr && bus_wdata[CTL_START];
  assign stop_cmd  = ctrl_wr && bus_wdata[CTL_STOP];

  logic unused_wdata;
  assign unused_wdata = ^bus_wdata[DATA_W-1:HALF_W];

  // one period half register per slice
  for (genvar h = 0; h < NHALF; h++) begin : g_per
    assign per_hit[h]  = bus_wen && (bus_addr == ADDR_W'(REG_PER_LO + h));
    assign per_next[h] = per_hit[h] ? bus_wdata[HALF_W-1:0] : per_q[h];
    assign snap_h[h]   = snap[h*HALF_W +: HALF_W];

    always_ff @(posedge clk) begin
      if (!rst_n) per_q[h] <= '0;
      else        per_q[h] <= per_next[h];
    end
  end

  assign per_wr   = |per_hit;
  assign period   = per_q;
  assign load_val = per_next;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ie      <= 1'b0;
      cont    <= 1'b0;
      run     <= 1'b0;
      to_flag <= 1'b0;
      snap    <= '0;
    end else begin
      if (ctrl_wr) begin
        ie   <= bus_wdata[CTL_IE];
        cont <= bus_wdata[CTL_CONT];
      end
      // halt commands outrank start; start outranks a one-shot finish
      if (per_wr || stop_cmd)  run <= 1'b0;
      else if (start_cmd)      run <= 1'b1;
      else if (done && !cont)  run <= 1'b0;

      if (done)         to_flag <= 1'b1;
      else if (stat_wr) to_flag <= 1'b0;

      if (snap_wr) snap <= cnt;
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      REG_STAT: begin
        bus_rdata[ST_TO]  = to_flag;
        bus_rdata[ST_RUN] = run;
      end
      REG_CTRL: begin
        bus_rdata[CTL_IE]   = ie;
        bus_rdata[CTL_CONT] = cont;
      end
      default: begin
        for (int h = 0; h < NHALF; h++) begin
          if (bus_addr == ADDR_W'(REG_PER_LO + h))
            bus_rdata[HALF_W-1:0] = per_q[h];
          if (bus_addr == ADDR_W'(REG_SNAP_LO + h))
            bus_rdata[HALF_W-1:0] = snap_h[h];
        end
      end
    endcase
  end
endmodule

// File: rtl/itimer_top.sv
module itimer_top
  import itimer_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int HALF_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wen,
  input  logic [2:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  logic [CNT_W-1:0] cnt, period, load_val, snap;
  logic per_wr, run, to_flag, ie, cont, done;

  itimer_regfile #(.CNT_W(CNT_W), .HALF_W(HALF_W), .DATA_W(DATA_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wen  (bus_wen),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .cnt      (cnt),
    .done     (done),
    .period   (period),
    .load_val (load_val),
    .per_wr   (per_wr),
    .run      (run),
    .to_flag  (to_flag),
    .ie       (ie),
    .cont     (cont),
    .snap     (snap)
  );

  itimer_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (per_wr),
    .load_val(load_val),
    .run     (run),
    .cont    (cont),
    .period  (period),
    .cnt     (cnt),
    .done    (done)
  );

  assign irq = to_flag & ie;
endmodule

// File: rtl/itimer_chk.sv
module itimer_chk
  import itimer_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int HALF_W = 16,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wen,
  input logic [2:0]        bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              irq,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  period,
  input logic [CNT_W-1:0]  snap,
  input logic              run,
  input logic              to_flag,
  input logic              ie,
  input logic              cont
);
  logic per_w, ctl_w, st_w, sn_w, tc;
  assign per_w = bus_wen && (bus_addr == REG_PER_LO || bus_addr == REG_PER_HI);
  assign ctl_w = bus_wen && (bus_addr == REG_CTRL);
  assign st_w  = bus_wen && (bus_addr == REG_STAT);
  assign sn_w  = bus_wen && (bus_addr == REG_SNAP_LO);
  assign tc    = run && (cnt == '0) && !per_w;

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DATA_W-1:HALF_W] == '0); // R1
  AST_PERIOD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    per_w |=> (!run && cnt == period)); // R2
  AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_w && bus_wdata[CTL_STOP]) |=> !run); // R3
  AST_START_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_w && bus_wdata[CTL_START] && !bus_wdata[CTL_STOP]) |=> run); // R3
  AST_DOWN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt != '0 && !per_w) |=> cnt == $past(cnt) - CNT_W'(1)); // R4
  AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !per_w) |=> $stable(cnt)); // R4
  AST_TC_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    tc |=> to_flag); // R5
  AST_TC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (tc && cont) |=> cnt == period); // R6
  AST_TC_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (tc && !cont && !(ctl_w && bus_wdata[CTL_START])) |=> (!run && cnt == '0)); // R6
  AST_STAT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (st_w && !tc) |=> !to_flag); // R7
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !ie |-> !irq); // R8
  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> to_flag); // R8
  AST_SNAP_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    sn_w |=> snap == $past(cnt)); // R9
endmodule

bind itimer_top itimer_chk #(.CNT_W(CNT_W), .HALF_W(HALF_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/itimer_top_tb_top.sv
module itimer_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wen = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int tests = 0;
  int fails = 0;
  bit done_flag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  itimer_top dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wen(bus_wen), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the falling edge after the write edge
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_wen = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wen = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic take_snap(output logic [31:0] v);
    logic [31:0] lo, hi;
    wr(3'd4, 32'h0);
    rd(3'd4, lo);
    rd(3'd5, hi);
    v = {hi[15:0], lo[15:0]};
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int a = 0; a < 8; a++) begin
      rd(a[2:0], v);
      chk("R11 reset register read", v, 32'h0);
    end
    chk("R11 reset irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_period_load;
    logic [31:0] v, s1, s2;
    wr(3'd1, 32'h8);
    wr(3'd2, 32'hABCD_1234);
    rd(3'd2, v);
    chk("R1 period low keeps bits 15:0", v, 32'h0000_1234);
    wr(3'd3, 32'h0000_0000);
    take_snap(s1);
    chk("R2 period loaded into counter", s1, 32'h1234);
    idle(5);
    take_snap(s2);
    chk("R4 halted counter holds", s2, 32'h1234);
    rd(3'd0, v);
    chk("R2 period write leaves timer halted", v, 32'h0);
  endtask

  task automatic t_one_shot;
    logic [31:0] v;
    wr(3'd2, 32'd5);
    wr(3'd3, 32'd0);
    wr(3'd1, 32'h4);
    idle(2);
    take_snap(v);
    chk("R4 down count after three clocks", v, 32'd3);
    idle(2);
    rd(3'd0, v);
    chk("R5 running at zero, flag not yet set", v, 32'h2);
    idle(1);
    rd(3'd0, v);
    chk("R5 R6 terminal sets flag and halts one-shot", v, 32'h1);
    chk("R8 irq masked while enable off", {31'b0, irq}, 32'h0);
    take_snap(v);
    chk("R6 one-shot stays at zero", v, 32'h0);
    wr(3'd0, 32'h0);
    rd(3'd0, v);
    chk("R7 status write clears flag", v, 32'h0);
  endtask

  task automatic t_continuous;
    logic [31:0] v;
    wr(3'd2, 32'd3);
    wr(3'd3, 32'd0);
    wr(3'd1, 32'h7);
    rd(3'd1, v);
    chk("R1 control reads enable and repeat bits", v, 32'h3);
    idle(3);
    rd(3'd0, v);
    chk("R5 no flag before terminal event", v, 32'h2);
    idle(1);
    rd(3'd0, v);
    chk("R6 repeat mode keeps running with flag", v, 32'h3);
    chk("R8 irq raised", {31'b0, irq}, 32'h1);
    take_snap(v);
    chk("R6 reloaded from period", v, 32'd3);
    wr(3'd0, 32'h0);
    chk("R7 R8 clear drops irq", {31'b0, irq}, 32'h0);
    wr(3'd1, 32'h2);
    idle(10);
    rd(3'd0, v);
    chk("R6 still running and flag set again", v, 32'h3);
    chk("R8 irq stays low with enable off", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_stop_start;
    logic [31:0] v, a, b;
    wr(3'd1, 32'hE);
    rd(3'd0, v);
    chk("R3 stop wins over start", v & 32'h2, 32'h0);
    take_snap(a);
    idle(5);
    take_snap(b);
    chk("R3 R4 stopped count frozen", b, a);
    wr(3'd1, 32'h6);
    rd(3'd0, v);
    chk("R3 start resumes running", v & 32'h2, 32'h2);
    take_snap(b);
    chk("R3 start does not reload", b, a);
    wr(3'd2, 32'd9);
    rd(3'd0, v);
    chk("R2 period write halts running timer", v & 32'h2, 32'h0);
    take_snap(v);
    chk("R2 counter holds new period", v, 32'd9);
  endtask

  task automatic t_clear_race;
    logic [31:0] v;
    wr(3'd2, 32'd0);
    wr(3'd3, 32'd0);
    wr(3'd1, 32'h6);
    idle(2);
    wr(3'd0, 32'h0);
    rd(3'd0, v);
    chk("R7 terminal event beats same-edge clear", v & 32'h1, 32'h1);
    wr(3'd1, 32'h8);
    wr(3'd0, 32'h0);
    rd(3'd0, v);
    chk("R7 clear after halt", v, 32'h0);
  endtask

  task automatic t_free_run;
    logic [31:0] v;
    wr(3'd0, 32'h0);
    wr(3'd1, 32'h0);
    wr(3'd1, 32'h8);
    wr(3'd2, 32'hFFFF);
    wr(3'd3, 32'hFFFF);
    wr(3'd1, 32'h6);
    take_snap(v);
    chk("R10 inverted count starts at zero", ~v, 32'd0);
    idle(10);
    take_snap(v);
    chk("R10 inverted count tracks clocks", ~v, 32'd11);
  endtask

  task automatic t_snap_any_data;
    logic [31:0] v;
    wr(3'd1, 32'h8);
    wr(3'd2, 32'd77);
    wr(3'd3, 32'd1);
    wr(3'd4, 32'hDEAD_BEEF);
    rd(3'd4, v);
    chk("R9 snapshot low after write of any data", v, 32'd77);
    rd(3'd5, v);
    chk("R9 snapshot high half", v, 32'd1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done_flag) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    t_reset();
    t_period_load();
    t_one_shot();
    t_continuous();
    t_stop_start();
    t_clear_race();
    t_free_run();
    t_snap_any_data();
    done_flag = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule